// File: doc/BRIEF.md
# Flash program/erase command controller

This block models how a serial NOR flash handles program and erase commands. It holds a small on-chip byte array. Commands arrive already decoded; no serial bit decoding happens here. A write-enable latch gates every program and erase. Each accepted operation runs an internal busy cycle of a fixed number of clocks, and each operation has its own length. Two status bytes report that cycle, so a host can poll until the cycle finishes.

A page program collects data bytes into a page buffer. The start address sets the starting offset, and the offset wraps within the page. When the cycle ends, the buffered bytes are ANDed into the array, so programming can only clear bits. Erases set a subsector, a sector or the whole array to 0xFF. Subsector erase is allowed only in the lowest sectors, which are the boot region, and it is refused entirely when the part is configured as uniform. The array changes only in the clock where the busy cycle ends.

Top module: `flash_pe_ctrl`

## Requirements
- R1: A write-enable command (code 1) sent while idle sets the write-enable latch, which reads at status_reg bit 1.
- R2: A page program (code 2) or any erase (codes 3, 4, 5) that arrives while the latch is 0 is ignored: no busy cycle starts and the array stays unchanged.
- R3: A page program stores its data bytes at consecutive offsets, beginning at the command address. The new array byte is the old byte ANDed with the data byte.
- R4: Offsets wrap from the last byte of a page to its first byte. Bytes outside the page are untouched. If one offset receives data twice, the later byte is the one used.
- R5: From the clock edge that accepts an operation, the busy cycle lasts exactly T_PP, T_SSE, T_SE or T_BE clocks, according to the operation.
- R6: During the busy cycle, status_reg bit 0 reads 1 and flag_status bit 7 reads 0. While idle, bit 0 reads 0 and bit 7 reads 1.
- R7: A subsector erase is accepted only when the sector index (address divided by SECT_BYTES) is below BOOT_SECTORS and UNIFORM is 0. Otherwise it is rejected: no busy cycle starts and the latch clears.
- R8: A subsector erase (code 3) sets its SUB_BYTES-aligned block to 0xFF. A sector erase (code 4) sets its SECT_BYTES-aligned block to 0xFF. A bulk erase (code 5) sets the whole array to 0xFF.
- R9: The array update, the fall of the busy bit and the clearing of the latch all happen at the same clock edge. The array is frozen while the cycle runs.
- R10: Every command, write enable included, is ignored while the busy cycle runs.
- R11: After reset, both status bits in status_reg read 0, flag_status reads 0x80 and every array byte reads 0xFF.
- R12: A page program that ends with no data bytes starts no cycle and clears the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 3 | 0 none, 1 write enable, 2 page program, 3 subsector erase, 4 sector erase, 5 bulk erase |
| cmd_addr | input | ADDR_W | Target byte address of the command |
| pp_valid | input | 1 | A program data byte is present |
| pp_data | input | 8 | Program data byte |
| pp_end | input | 1 | Ends the page-program data phase |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr, combinational |
| status_reg | output | 8 | Bit 0 write in progress, bit 1 write-enable latch, other bits 0 |
| flag_status | output | 8 | Bit 7 controller ready (1 when idle), other bits 0 |

## Verification
The first sign of a wrong latch or a wrong acceptance decision is a busy bit that rises, or fails to rise, at the negative edge after the command. The bench checks that edge on every operation. A wrong cycle counter shows up as a busy length that differs from the operation's parameter. A wrong range decode or a wrong buffer offset changes array bytes. The bench finds those by reading back the whole array in the cycle where busy falls, and by reading a target byte while busy is still high to confirm the old value is still there.

// File: rtl/flash_pe_pkg.sv
// Shared types for the flash program/erase controller.
// Assumes: command codes are fixed by the external decoder.
package flash_pe_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_WREN = 3'd1,
        OP_PP   = 3'd2,
        OP_SSE  = 3'd3,
        OP_SE   = 3'd4,
        OP_BE   = 3'd5
    } pe_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } pe_state_e;
endpackage

// File: rtl/flash_pe_timer.sv
// Busy-cycle timer. A start pulse loads a length and raises busy. Busy then
// stays high for exactly that many clocks, and done marks the final clock.
// Assumes: start only arrives while busy is low, and start_len is at least 1.
module flash_pe_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_len,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down while busy, drop busy after the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= start_len - CNT_W'(1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Marks the clock in which the cycle completes.
    always_comb done = busy && (cnt_q == '0);
endmodule

// File: rtl/flash_pe_cmd.sv
// Command acceptance and write-enable latch. Decides which commands run,
// tracks the page-program data phase and the page offset, and picks the
// cycle length for the timer.
// Assumes: busy and done come from the timer, and commands are one-cycle pulses.
module flash_pe_cmd
    import flash_pe_pkg::*;
#(
    parameter int          ADDR_W       = 9,
    parameter int          PAGE_W       = 4,
    parameter int          SECT_W       = 6,
    parameter int unsigned BOOT_SECTORS = 2,
    parameter bit          UNIFORM      = 1'b0,
    parameter int          CNT_W        = 5,
    parameter int          T_PP         = 8,
    parameter int          T_SSE        = 12,
    parameter int          T_SE         = 16,
    parameter int          T_BE         = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              pp_valid,
    input  logic              pp_end,
    input  logic              busy,
    input  logic              done,
    output logic              wel,
    output logic              start,
    output logic [CNT_W-1:0]  start_len,
    output logic              buf_clear,
    output logic              buf_wr,
    output logic [PAGE_W-1:0] buf_off,
    output pe_op_e            op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              loading
);
    pe_state_e         state_q;
    logic              got_q;
    logic [PAGE_W-1:0] off_q;
    pe_op_e            op;
    logic              take, boot_ok, pp_go, erase_go, sse_bad, got_any, load_end;

    // Acceptance decisions for the current cycle.
    always_comb begin
        op        = pe_op_e'(cmd_code);
        take      = cmd_valid && !busy && (state_q == ST_IDLE);
        boot_ok   = !UNIFORM && ((cmd_addr >> SECT_W) < ADDR_W'(BOOT_SECTORS));
        pp_go     = take && wel && (op == OP_PP);
        erase_go  = take && wel && ((op == OP_SE) || (op == OP_BE) ||
                                    ((op == OP_SSE) && boot_ok));
        sse_bad   = take && wel && (op == OP_SSE) && !boot_ok;
        got_any   = got_q || pp_valid;
        load_end  = (state_q == ST_LOAD) && pp_end;
        start     = erase_go || (load_end && got_any);
        buf_clear = pp_go;
        buf_wr    = (state_q == ST_LOAD) && pp_valid;
        buf_off   = off_q;
        loading   = (state_q == ST_LOAD);
    end

    // Cycle length for the operation being started.
    always_comb begin
        if (load_end) start_len = CNT_W'(T_PP);
        else begin
            unique case (op)
                OP_SSE:  start_len = CNT_W'(T_SSE);
                OP_SE:   start_len = CNT_W'(T_SE);
                default: start_len = CNT_W'(T_BE);
            endcase
        end
    end

    // Latch, data-phase state and captured command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wel     <= 1'b0;
            got_q   <= 1'b0;
            off_q   <= '0;
            op_q    <= OP_NOP;
            addr_q  <= '0;
        end else begin
            if (done) wel <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (take && op == OP_WREN) wel <= 1'b1;
                if (pp_go) begin
                    state_q <= ST_LOAD;
                    got_q   <= 1'b0;
                    off_q   <= cmd_addr[PAGE_W-1:0];
                end
                if (pp_go || erase_go) begin
                    op_q   <= op;
                    addr_q <= cmd_addr;
                end
                if (sse_bad) wel <= 1'b0;
            end else begin
                if (pp_valid) begin
                    off_q <= off_q + PAGE_W'(1);
                    got_q <= 1'b1;
                end
                if (pp_end) begin
                    state_q <= ST_IDLE;
                    if (!got_any) wel <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/flash_pe_array.sv
// Byte array with a page buffer. Collects program bytes together with a
// written mask. On the apply pulse it ANDs the buffer into the page, or sets
// the erase range to 0xFF. Reads are combinational.
// Assumes: apply is a single-cycle pulse, and the buffer is not written during apply.
module flash_pe_array
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4,
    parameter int SUB_W  = 5,
    parameter int SECT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_clear,
    input  logic              buf_wr,
    input  logic [PAGE_W-1:0] buf_off,
    input  logic [7:0]        buf_data,
    input  logic              apply,
    input  pe_op_e            apply_op,
    input  logic [ADDR_W-1:0] apply_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [7:0] mem  [DEPTH];
    logic [7:0] pbuf [PAGE];
    logic       pmask[PAGE];

    // Page buffer: cleared at program start, filled by data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || buf_clear) begin
            for (int j = 0; j < PAGE; j++) begin
                pbuf[j]  <= 8'hFF;
                pmask[j] <= 1'b0;
            end
        end else if (buf_wr) begin
            pbuf[buf_off]  <= buf_data;
            pmask[buf_off] <= 1'b1;
        end
    end

    // Array update: erased at reset, changed only on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (apply) begin
            for (int i = 0; i < DEPTH; i++) begin
                logic [ADDR_W-1:0] ia;
                ia = ADDR_W'(i);
                unique case (apply_op)
                    OP_PP: if ((ia >> PAGE_W) == (apply_addr >> PAGE_W) && pmask[ia[PAGE_W-1:0]])
                               mem[i] <= mem[i] & pbuf[ia[PAGE_W-1:0]];
                    OP_SSE: if ((ia >> SUB_W) == (apply_addr >> SUB_W)) mem[i] <= 8'hFF;
                    OP_SE:  if ((ia >> SECT_W) == (apply_addr >> SECT_W)) mem[i] <= 8'hFF;
                    OP_BE:  mem[i] <= 8'hFF;
                    default: ;
                endcase
            end
        end
    end

    // Combinational read port.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_pe_ctrl.sv
// Top of the flash program/erase controller. Connects command acceptance,
// the busy timer and the array, and assembles the two polling status bytes.
// Assumes: sizes are powers of two, PAGE_BYTES <= SUB_BYTES <= SECT_BYTES,
// and every cycle length is at least 2.
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int          PAGE_BYTES   = 16,
    parameter int          SUB_BYTES    = 32,
    parameter int          SECT_BYTES   = 64,
    parameter int          SECTORS      = 8,
    parameter int unsigned BOOT_SECTORS = 2,
    parameter bit          UNIFORM      = 1'b0,
    parameter int          T_PP         = 8,
    parameter int          T_SSE        = 12,
    parameter int          T_SE         = 16,
    parameter int          T_BE         = 24,
    localparam int         ADDR_W       = $clog2(SECTORS * SECT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              pp_valid,
    input  logic [7:0]        pp_data,
    input  logic              pp_end,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        status_reg,
    output logic [7:0]        flag_status
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int SUB_W  = $clog2(SUB_BYTES);
    localparam int SECT_W = $clog2(SECT_BYTES);
    localparam int T_M1   = (T_PP > T_SSE) ? T_PP : T_SSE;
    localparam int T_M2   = (T_SE > T_BE) ? T_SE : T_BE;
    localparam int T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    logic              wel, busy, done, start, buf_clear, buf_wr, loading;
    logic [CNT_W-1:0]  start_len;
    logic [PAGE_W-1:0] buf_off;
    pe_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;

    flash_pe_cmd #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W),
        .BOOT_SECTORS(BOOT_SECTORS), .UNIFORM(UNIFORM), .CNT_W(CNT_W),
        .T_PP(T_PP), .T_SSE(T_SSE), .T_SE(T_SE), .T_BE(T_BE)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .pp_valid(pp_valid), .pp_end(pp_end),
        .busy(busy), .done(done), .wel(wel), .start(start), .start_len(start_len),
        .buf_clear(buf_clear), .buf_wr(buf_wr), .buf_off(buf_off),
        .op_q(op_q), .addr_q(addr_q), .loading(loading)
    );

    flash_pe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
        .busy(busy), .done(done)
    );

    flash_pe_array #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SUB_W(SUB_W), .SECT_W(SECT_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_wr(buf_wr),
        .buf_off(buf_off), .buf_data(pp_data), .apply(done), .apply_op(op_q),
        .apply_addr(addr_q), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Polling bytes: busy flag, latch, and controller-ready flag.
    always_comb begin
        status_reg  = {6'b0, wel, busy};
        flag_status = {~busy, 7'b0};
    end
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
// Property checker for flash_pe_ctrl, attached with bind.
// Assumes: the default parameters give every cycle a length of at least 2.
module flash_pe_ctrl_chk #(
    parameter int          ADDR_W       = 9,
    parameter int          SECT_W       = 6,
    parameter int unsigned BOOT_SECTORS = 2,
    parameter bit          UNIFORM      = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [7:0]        status_reg,
    input logic              loading
);
    logic boot;
    always_comb boot = !UNIFORM && ((cmd_addr >> SECT_W) < ADDR_W'(BOOT_SECTORS));

    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_reg[0]) |-> $past(status_reg[1])); // R2
    AST_MIN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_reg[0]) |=> status_reg[0]); // R5
    AST_SSE_OUTSIDE_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == 3'd3 && !status_reg[0] && !loading && !boot
        |=> !status_reg[0] && !status_reg[1]); // R7
    AST_WEL_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_reg[0]) |-> !status_reg[1]); // R9
    AST_ARRAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        status_reg[0] && $past(status_reg[0]) && $stable(rd_addr) |-> $stable(rd_data)); // R9
    AST_BUSY_IGNORES_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
        status_reg[0] |=> !$rose(status_reg[1])); // R10
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .BOOT_SECTORS(BOOT_SECTORS), .UNIFORM(UNIFORM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .rd_addr(rd_addr), .rd_data(rd_data),
    .status_reg(status_reg), .loading(loading)
);

// File: tb/tb_flash_pe_ctrl.sv
// Bench for flash_pe_ctrl: directed corner cases, then seeded random
// operations, all checked against a behavioural model of the array.
module tb_flash_pe_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int T_PP = 8, T_SSE = 12, T_SE = 16, T_BE = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [8:0] cmd_addr = '0;
    logic       pp_valid = 1'b0;
    logic [7:0] pp_data = '0;
    logic       pp_end = 1'b0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data, status_reg, flag_status;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] mem_m [DEPTH];
    bit wel_m;

    flash_pe_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .pp_valid(pp_valid), .pp_data(pp_data), .pp_end(pp_end),
        .rd_addr(rd_addr), .rd_data(rd_data), .status_reg(status_reg),
        .flag_status(flag_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic [7:0] pat(input logic [7:0] b, input int k);
        return b + 8'(k * 37);
    endfunction

    function automatic bit is_boot(input logic [8:0] a);
        return (a >> 6) < 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic read_byte(input logic [8:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic compare_all(input string tag);
        int bad = 0;
        int ba = 0;
        logic [7:0] v, bv, be;
        bv = 0;
        be = 0;
        for (int a = 0; a < DEPTH; a++) begin
            read_byte(9'(a), v);
            if (v !== mem_m[a]) begin
                if (bad == 0) begin
                    ba = a;
                    bv = v;
                    be = mem_m[a];
                end
                bad++;
            end
        end
        chk(bad == 0, $sformatf("%s array byte %0h", tag, ba), bv, be);
    endtask

    task automatic send_cmd(input logic [2:0] code, input logic [8:0] a);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_addr  = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Called at the first negedge after acceptance. Checks the busy flags,
    // the old value of probe, and the cycle length.
    task automatic run_cycle(input int t, input logic [8:0] probe, input bit inject,
                             input string tag);
        int cnt = 0;
        logic [7:0] v;
        if (t == 0) begin
            chk(status_reg[0] == 1'b0, {tag, " R2 no cycle"}, status_reg[0], 0);
            return;
        end
        chk(status_reg[0] == 1'b1 && flag_status[7] == 1'b0, {tag, " R6 busy flags"},
            {status_reg[0], flag_status[7]}, 2);
        read_byte(probe, v);
        chk(v == mem_m[probe], {tag, " R9 frozen while busy"}, v, mem_m[probe]);
        if (inject) begin
            send_cmd(3'd1, probe);
            send_cmd(3'd4, probe);
            cnt = 4;
        end
        while (status_reg[0] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == t, {tag, " R5 cycle length"}, cnt, t);
    endtask

    task automatic finish_op(input string tag);
        chk(status_reg[1] == wel_m && flag_status[7] == 1'b1, {tag, " R9 latch after op"},
            {status_reg[1], flag_status[7]}, {wel_m, 1'b1});
        compare_all(tag);
    endtask

    task automatic wren(input string tag);
        send_cmd(3'd1, 9'd0);
        wel_m = 1'b1;
        chk(status_reg[1] == 1'b1, {tag, " R1 latch set"}, status_reg[1], 1);
    endtask

    task automatic do_pp(input logic [8:0] a, input int n, input logic [7:0] b,
                         input bit inject, input string tag);
        logic [7:0] pbuf [16];
        bit         pm   [16];
        logic [3:0] off = a[3:0];
        bit pre = wel_m;
        int t;
        for (int j = 0; j < 16; j++) pm[j] = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = 3'd2;
        cmd_addr  = a;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            pp_valid  = 1'b1;
            pp_data   = pat(b, k);
            pbuf[off] = pat(b, k);
            pm[off]   = 1'b1;
            off++;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        pp_valid  = 1'b0;
        pp_end    = 1'b1;
        @(negedge clk);
        pp_end = 1'b0;
        t = (pre && n > 0) ? T_PP : 0;
        run_cycle(t, a, inject, tag);
        if (t != 0)
            for (int j = 0; j < 16; j++)
                if (pm[j]) mem_m[{a[8:4], 4'(j)}] &= pbuf[j];
        if (pre) wel_m = 1'b0;
        finish_op(tag);
    endtask

    task automatic do_erase(input logic [2:0] code, input logic [8:0] a, input string tag);
        bit acc;
        int t;
        acc = wel_m && (code != 3'd3 || is_boot(a));
        t = !acc ? 0 : (code == 3'd3) ? T_SSE : (code == 3'd4) ? T_SE : T_BE;
        send_cmd(code, a);
        run_cycle(t, a, 1'b0, tag);
        if (acc)
            for (int i = 0; i < DEPTH; i++) begin
                logic [8:0] ia = 9'(i);
                if (code == 3'd5 || (code == 3'd4 && ia[8:6] == a[8:6]) ||
                    (code == 3'd3 && ia[8:5] == a[8:5]))
                    mem_m[i] = 8'hFF;
            end
        if (wel_m) wel_m = 1'b0;
        finish_op(tag);
    endtask

    initial begin
        int unsigned s;
        s = $urandom(32'd4711);
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
        wel_m = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(status_reg == 8'h00, "R11 status after reset", status_reg, 0);
        chk(flag_status == 8'h80, "R11 flag after reset", flag_status, 8'h80);
        compare_all("R11 reset array");

        // R2 program and erase without the latch
        do_pp(9'h010, 3, 8'h12, 1'b0, "R2 pp no latch");
        do_erase(3'd4, 9'h000, "R2 se no latch");

        // R3 R4 wrapping program, then AND over the same bytes
        wren("R1");
        do_pp(9'h00E, 5, 8'h5A, 1'b0, "R4 wrap pp");
        wren("R1");
        do_pp(9'h00E, 5, 8'hC3, 1'b0, "R3 and pp");
        // R4 run longer than a page: later bytes win
        wren("R1");
        do_pp(9'h023, 18, 8'h77, 1'b0, "R4 last wins");
        // R12 program with no data
        wren("R1");
        do_pp(9'h030, 0, 8'h00, 1'b0, "R12 empty pp");
        // R7 R8 subsector erase inside and outside the boot region
        wren("R1");
        do_erase(3'd3, 9'h000, "R7 sse boot");
        wren("R1");
        do_pp(9'h105, 4, 8'h3C, 1'b0, "R3 pp high");
        wren("R1");
        do_erase(3'd3, 9'h100, "R7 sse rejected");
        // R10 commands ignored while busy
        wren("R1");
        do_pp(9'h140, 2, 8'h0F, 1'b1, "R10 busy ignore");
        wren("R1");
        do_erase(3'd4, 9'h140, "R8 sector erase");
        wren("R1");
        do_pp(9'h1F0, 6, 8'h81, 1'b0, "R3 pp top");
        wren("R1");
        do_erase(3'd5, 9'h000, "R8 bulk erase");

        // Seeded random operations
        for (int it = 0; it < 40; it++) begin
            int op = int'($urandom_range(0, 3));
            logic [8:0] a = 9'($urandom_range(0, DEPTH - 1));
            if ($urandom_range(0, 3) != 0) wren("R1 rnd");
            case (op)
                0, 1: do_pp(a, int'($urandom_range(0, 20)), 8'($urandom), 1'b0, "R3 rnd pp");
                2: do_erase(3'd3, a, "R7 rnd sse");
                default: do_erase(($urandom_range(0, 5) == 0) ? 3'd5 : 3'd4, a, "R8 rnd erase");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule